// File: doc/BRIEF.md
# Serial Calibration Trim Loader

This block takes the bit-serial stream that software produces by repeated writes to a 16-bit configuration word, and turns it into a bank of 8-bit calibration trim values. It stands in for three trim converters of eight channels each. All three listen on one shared data bit and one shared clock bit. A 2-bit select field in the same word decides which converter, if any, takes the frame that has just been shifted in.

Software presents each data bit with the clock bit low, then raises the clock bit while holding the data. After eleven bits, sent most significant first as a 3-bit channel address and then an 8-bit value, it pulses the select field. It writes a nonzero code and then writes zero again. The addressed trim output takes the value. Of the 24 outputs, global channel c belongs to converter c/8, local channel c mod 8. Calibration uses 21 of them; converter 2's channels 5..7 are spare but still hold values.

Top module: `trim_dac_loader`

## Requirements
- R1: After reset every one of the 24 trim outputs reads 0x80.
- R2: A bit is shifted in only on a write in which the clock bit (bit 1) is 1 and the clock bit held 0 before that write. The shifted bit is the data bit (bit 0) of that write. Writes that keep the clock bit high or bring it low shift nothing.
- R3: A frame is the last 11 bits shifted in before the load, oldest first. Its top 3 bits are the local channel and its low 8 bits are the value. Bits shifted in before those 11 have no effect.
- R4: Bits 15:14 of the write form the select field. Code 1, 2 or 3 loads converter 0, 1 or 2. The value goes to global channel (code-1)*8 + local channel, which is output bits [8*c+7:8*c] of `trim_vals`.
- R5: A load happens only on a write that changes the select field from 0 to nonzero. Further writes that keep it nonzero load nothing. This holds when the field moves to another nonzero code, and when new bits are shifted meanwhile.
- R6: Writes whose select field is 0 never change any trim output. Bits 13:2 of the write are ignored.
- R7: A load changes only the addressed channel; all other outputs keep their values.
- R8: The new value is visible on `trim_vals` in the cycle after the load write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word: bit 0 data, bit 1 clock, bits 15:14 select field |
| trim_vals | output | 192 | 24 trim values, channel c at bits [8*c+7:8*c] |

## Verification
The bench pads frames with junk leading bits. A design that kept the oldest bits instead of the newest would load the wrong channel or value. It also repeats writes with the clock held high and drops the clock with data set. A design shifting on level or falling edge would corrupt the frame. It holds the select field nonzero across new frames and moves it from one nonzero code to another. A design loading on level rather than on the 0-to-nonzero change would overwrite trims. Randomised loads across all 24 channels compare the whole output bus, so writing a neighbouring channel or the wrong converter shows at once.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int NUM_CONV    = 3;
    localparam int CH_PER_CONV = 8;
    localparam int VAL_W       = 8;
    localparam int ADDR_W      = $clog2(CH_PER_CONV);
    localparam int FRAME_W     = ADDR_W + VAL_W;
    localparam int FIELD_W     = 2;
    localparam int CFG_W       = 16;
    localparam int NUM_TRIM    = NUM_CONV * CH_PER_CONV;
    localparam int DATA_BIT    = 0;
    localparam int CLK_BIT     = 1;
    localparam int FIELD_LSB   = 14;
    localparam logic [VAL_W-1:0] MID_SCALE = 8'h80;

    typedef struct packed {
        logic [ADDR_W-1:0] chan;
        logic [VAL_W-1:0]  value;
    } frame_t;

    function automatic logic [NUM_CONV-1:0] field_to_sel(input logic [FIELD_W-1:0] f);
        logic [NUM_CONV-1:0] s;
        s = '0;
        for (int k = 0; k < NUM_CONV; k++) begin
            if (f == FIELD_W'(k + 1)) s[k] = 1'b1;
        end
        return s;
    endfunction
endpackage

// File: rtl/trim_serial_shift.sv
module trim_serial_shift
    import trim_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  logic   sclk_in,
    input  logic   sdata_in,
    output frame_t frame
);
    logic               sclk_q;
    logic [FRAME_W-1:0] shreg;
    logic               rise;

    assign rise  = wr && sclk_in && !sclk_q;
    assign frame = frame_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
        end else if (wr) begin
            sclk_q <= sclk_in;
            if (rise) shreg <= {shreg[FRAME_W-2:0], sdata_in};
        end
    end

    assert_shift_capture_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> (shreg[0] == $past(sdata_in)) && (shreg[FRAME_W-1:1] == $past(shreg[FRAME_W-2:0])));

    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr || !sclk_in || sclk_q) |=> $stable(shreg));
endmodule

// File: rtl/trim_load_decode.sv
module trim_load_decode
    import trim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [FIELD_W-1:0]  field_in,
    output logic [NUM_CONV-1:0] ld_sel
);
    logic [FIELD_W-1:0] field_q;
    logic               strobe;

    assign strobe = wr && (field_in != '0) && (field_q == '0);
    assign ld_sel = strobe ? field_to_sel(field_in) : '0;

    always_ff @(posedge clk) begin
        if (rst)     field_q <= '0;
        else if (wr) field_q <= field_in;
    end

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_sel));

    assert_single_load_R5: assert property (@(posedge clk) disable iff (rst)
        (|ld_sel) |=> !(|ld_sel));

    assert_zero_field_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (field_in == '0) |-> !(|ld_sel));
endmodule

// File: rtl/trim_bank.sv
module trim_bank
    import trim_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_en,
    input  logic [ADDR_W-1:0]              ld_chan,
    input  logic [VAL_W-1:0]               ld_val,
    output logic [CH_PER_CONV*VAL_W-1:0]   vals
);
    logic [VAL_W-1:0] regs [CH_PER_CONV];

    for (genvar i = 0; i < CH_PER_CONV; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                                      regs[i] <= MID_SCALE;
            else if (ld_en && ld_chan == ADDR_W'(i))      regs[i] <= ld_val;
        end
        assign vals[i*VAL_W +: VAL_W] = regs[i];

        assert_other_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !(ld_en && ld_chan == ADDR_W'(i)) |=> $stable(vals[i*VAL_W +: VAL_W]));
    end

    assert_load_value_R8: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> regs[$past(ld_chan)] == $past(ld_val));
endmodule

// File: rtl/trim_dac_loader.sv
module trim_dac_loader
    import trim_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr,
    input  logic [15:0]                 cfg_wdata,
    output logic [NUM_TRIM*VAL_W-1:0]   trim_vals
);
    frame_t              frame;
    logic [NUM_CONV-1:0] ld_sel;

    trim_serial_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .sclk_in  (cfg_wdata[CLK_BIT]),
        .sdata_in (cfg_wdata[DATA_BIT]),
        .frame    (frame)
    );

    trim_load_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .field_in (cfg_wdata[FIELD_LSB +: FIELD_W]),
        .ld_sel   (ld_sel)
    );

    for (genvar k = 0; k < NUM_CONV; k++) begin : g_conv
        trim_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .ld_en   (ld_sel[k]),
            .ld_chan (frame.chan),
            .ld_val  (frame.value),
            .vals    (trim_vals[k*CH_PER_CONV*VAL_W +: CH_PER_CONV*VAL_W])
        );
    end

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(trim_vals));
endmodule

// File: tb/test_trim_dac_loader.sv
module test_trim_dac_loader;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_wr = 1'b0;
    logic [15:0]  cfg_wdata = '0;
    logic [191:0] trim_vals;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_v [24];
    bit done = 0;

    always #2 clk = ~clk;

    trim_dac_loader i_trim_dac_loader (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .trim_vals(trim_vals)
    );

    task automatic wr_word(input logic [1:0] fld, input logic ck, input logic d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {fld, 12'($urandom), ck, d};
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic send_bit(input logic b, input logic [1:0] fld);
        wr_word(fld, 1'b0, b);
        wr_word(fld, 1'b1, b);
    endtask

    task automatic send_frame(input logic [2:0] ch, input logic [7:0] v, input logic [1:0] fld);
        logic [10:0] f;
        f = {ch, v};
        for (int i = 10; i >= 0; i--) send_bit(f[i], fld);
    endtask

    task automatic strobe(input logic [1:0] code);
        wr_word(code, 1'b0, 1'b0);
    endtask

    task automatic check_bus(input string req);
        int bad = 0;
        checks++;
        for (int c = 0; c < 24; c++) begin
            if (trim_vals[8*c +: 8] !== exp_v[c]) begin
                if (bad == 0)
                    $display("FAIL %s ch%0d actual=%02h expected=%02h", req, c, trim_vals[8*c +: 8], exp_v[c]);
                bad++;
            end
        end
        if (bad != 0) fails++;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R1..R8 actual=timeout expected=completion");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < 24; c++) exp_v[c] = 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bus("R1 reset mid-scale");

        // R3: junk leading bits, then frame for local ch 3 on converter 0
        for (int i = 0; i < 5; i++) send_bit(1'b1, 2'd0);
        send_frame(3'd3, 8'h5A, 2'd0);
        check_bus("R6 no load while field zero");
        strobe(2'd1); exp_v[3] = 8'h5A;
        check_bus("R3 R4 R8 frame after junk to ch3");
        strobe(2'd0);

        // R4: converter 2, local 7 (global 23)
        send_frame(3'd7, 8'hC3, 2'd0);
        strobe(2'd3); exp_v[23] = 8'hC3;
        check_bus("R4 converter2 local7");
        strobe(2'd0);

        // R5: held nonzero field, new frame, change to another nonzero code
        send_frame(3'd2, 8'h11, 2'd0);
        strobe(2'd2); exp_v[10] = 8'h11;
        check_bus("R4 converter1 local2");
        send_frame(3'd6, 8'hEE, 2'd2);
        check_bus("R5 held field no reload");
        strobe(2'd3);
        check_bus("R5 nonzero to nonzero no load");
        strobe(2'd1);
        check_bus("R5 still nonzero no load");
        strobe(2'd0);

        // R2: clock held high with changing data, and falling writes, do not shift
        send_frame(3'd1, 8'h3C, 2'd0);
        wr_word(2'd0, 1'b1, 1'b1);
        wr_word(2'd0, 1'b1, 1'b0);
        wr_word(2'd0, 1'b1, 1'b1);
        wr_word(2'd0, 1'b0, 1'b1);
        wr_word(2'd0, 1'b0, 1'b0);
        strobe(2'd2); exp_v[9] = 8'h3C;
        check_bus("R2 no shift without rising clock");
        strobe(2'd0);

        // R6: frame without strobe changes nothing
        send_frame(3'd0, 8'h00, 2'd0);
        strobe(2'd0);
        check_bus("R6 zero field writes ignored");

        // R7 and R4: random loads across all 24 channels
        for (int n = 0; n < 40; n++) begin
            int c;
            logic [7:0] v;
            int junk;
            c = int'($urandom % 24);
            v = 8'($urandom);
            junk = int'($urandom % 4);
            for (int j = 0; j < junk; j++) send_bit(1'($urandom), 2'd0);
            send_frame(3'(c % 8), v, 2'd0);
            strobe(2'(c / 8 + 1)); exp_v[c] = v;
            check_bus("R7 random load only addressed channel");
            strobe(2'd0);
        end

        // R1: reset again restores mid-scale
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int c = 0; c < 24; c++) exp_v[c] = 8'h80;
        check_bus("R1 reset after loads");

        done = 1;
        finish_up();
    end
endmodule